// File: doc/BRIEF.md
# Multi-Game Cartridge Outer Bank Controller

This block holds the four outer-bank registers of a multi-game cartridge. The CPU loads them with plain writes anywhere in a 4 KiB window at 0x5000-0x5FFF. There is no register address. An internal 2-bit pointer picks the target register and moves on after each accepted write, wrapping after the fourth register. From the register contents the block derives four values: an AND mask and an OR base for the program (PRG) side, and the same pair for the character (CHR) side. These confine a selected game to its slice of the cartridge ROM. The registers also supply a core-select bit that chooses which of two inner banking cores is active.

Each inner core supplies its own bank numbers, one per slot: four PRG slots and eight CHR slots. The block merges each inner number with the outer values, (inner AND mask) OR base, and outputs the physical bank number for that slot. A multi-game menu program writes the four registers and then sets the lock bit. The lock freezes the outer state until the next reset, so the selected game cannot leave its slice.

The write that moves the pointer onto the last register marks the point where the chosen core must be set up again. The block signals this with a single-cycle pulse.

Top module: `outer_bank_ctrl`

## Requirements
- R1: After reset, register 2 holds 0x0F, registers 0, 1 and 3 hold 0, and the pointer is 0. So prg_and_o=0x3F, chr_and_o=0xFF, prg_or_o=0, chr_or_o=0, core_sel_o=0 and core_apply_o=0.
- R2: A write strobe with (cpu_addr_i & 0xF000)==0x5000 stores cpu_data_i into the register the pointer names, and the pointer then advances by one, modulo 4. Outputs reflect the new value in the cycle after the write edge.
- R3: Writes whose address lies outside 0x5000-0x5FFF change no register and do not advance the pointer.
- R4: While register 3 bit 7 is 1, window writes change no register and do not advance the pointer. Only reset clears this lock.
- R5: prg_and_o is the bitwise inverse of register 3 bits 5:0 (6 bits wide).
- R6: chr_and_o equals 0xFF shifted right by the inverse of register 2 bits 3:0.
- R7: prg_or_o (9 bits) takes register 1 in bits 7:0 and register 3 bit 6 in bit 8. Every bit that is set in prg_and_o is then cleared.
- R8: chr_or_o (13 bits) takes register 0 in bits 7:0, register 2 bits 7:4 in bits 11:8 and register 3 bit 6 in bit 12. Every bit that is set in chr_and_o is then cleared.
- R9: core_sel_o equals register 2 bit 7. A value of 1 selects the second inner core (IRQ counter clocked by CPU cycles) and 0 selects the first (scanline counter).
- R10: core_apply_o is 1 for exactly the one cycle after an accepted write that moves the pointer from 2 to 3. It is 0 at all other times.
- R11: For each slot s, prg_bank_o[s] = (prg_inner_i[s] & prg_and_o) | prg_or_o and chr_bank_o[s] = (chr_inner_i[s] & chr_and_o) | chr_or_o. Slot s sits at bit offset s times the slot width. These outputs are combinational in the inner inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU write address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | Write strobe, one per bus write |
| prg_inner_i | input | 24 | Four 6-bit PRG bank numbers from the inner core |
| chr_inner_i | input | 64 | Eight 8-bit CHR bank numbers from the inner core |
| prg_and_o | output | 6 | PRG inner-bank mask |
| prg_or_o | output | 9 | PRG outer base |
| chr_and_o | output | 8 | CHR inner-bank mask |
| chr_or_o | output | 13 | CHR outer base |
| prg_bank_o | output | 36 | Four merged 9-bit PRG bank numbers |
| chr_bank_o | output | 104 | Eight merged 13-bit CHR bank numbers |
| core_sel_o | output | 1 | Inner core select |
| core_apply_o | output | 1 | One-cycle request to set up the selected core again |

## Verification
The write into register 2 is the only write that raises core_apply_o, and the same write can also flip core_sel_o. The bench therefore makes that single write both set bit 7 and cross the pointer from 2 to 3. It then expects the new core select and the apply pulse in the same following cycle. A second case puts the locking write next to further window writes in back-to-back cycles, including one that would have crossed the pointer to 3. That write must leave the outputs unchanged and must not produce a pulse. A behavioural model that updates on every edge judges both cases, and it also judges randomly mixed window and off-window writes.

// File: rtl/obc_pkg.sv
package obc_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned NUM_REGS   = 4;
  localparam int unsigned IDX_W      = $clog2(NUM_REGS);
  localparam int unsigned PRG_AND_W  = 6;
  localparam int unsigned PRG_OR_W   = REG_W + 1;
  localparam int unsigned CHR_AND_W  = REG_W;
  localparam int unsigned CHR_OR_W   = REG_W + 5;
  localparam int unsigned SHIFT_W    = 4;
  localparam int unsigned LOCK_BIT   = 7;
  localparam int unsigned HIGH_BIT   = 6;
  localparam int unsigned SEL_BIT    = 7;
  localparam logic [REG_W-1:0] REG2_RST = 8'h0F;

  typedef logic [REG_W-1:0] reg_t;

  typedef struct packed {
    reg_t r3;
    reg_t r2;
    reg_t r1;
    reg_t r0;
  } outer_regs_t;

  typedef struct packed {
    logic [PRG_AND_W-1:0] prg_and;
    logic [PRG_OR_W-1:0]  prg_or;
    logic [CHR_AND_W-1:0] chr_and;
    logic [CHR_OR_W-1:0]  chr_or;
    logic                 core_sel;
  } outer_masks_t;
endpackage

// File: rtl/obc_regfile.sv
module obc_regfile
  import obc_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h5000,
  parameter logic [ADDR_W-1:0] WIN_MASK = 16'hF000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  data_i,
  input  logic              we_i,
  output outer_regs_t       regs_o,
  output logic              lock_o,
  output logic              apply_o
);
  localparam logic [IDX_W-1:0] APPLY_FROM = IDX_W'(NUM_REGS - 2);

  logic [IDX_W-1:0] idx_q;
  logic             hit, accept;
  reg_t             reg_q [NUM_REGS];

  assign hit    = we_i && ((addr_i & WIN_MASK) == WIN_BASE);
  assign lock_o = reg_q[NUM_REGS-1][LOCK_BIT];
  assign accept = hit && !lock_o;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam reg_t RST_VAL = (g == 2) ? REG2_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             reg_q[g] <= RST_VAL;
      else if (accept && idx_q == IDX_W'(g))   reg_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      apply_o <= 1'b0;
    end else begin
      apply_o <= accept && (idx_q == APPLY_FROM);
      if (accept) idx_q <= idx_q + 1'b1;
    end
  end

  assign regs_o = '{r3: reg_q[3], r2: reg_q[2], r1: reg_q[1], r0: reg_q[0]};
endmodule

// File: rtl/obc_mask_gen.sv
module obc_mask_gen
  import obc_pkg::*;
(
  input  outer_regs_t  regs_i,
  output outer_masks_t masks_o
);
  logic [SHIFT_W-1:0]   chr_shift;
  logic [PRG_AND_W-1:0] prg_and;
  logic [CHR_AND_W-1:0] chr_and;
  logic [PRG_OR_W-1:0]  prg_raw;
  logic [CHR_OR_W-1:0]  chr_raw;

  always_comb begin
    prg_and   = ~regs_i.r3[PRG_AND_W-1:0];
    chr_shift = ~regs_i.r2[SHIFT_W-1:0];
    chr_and   = {CHR_AND_W{1'b1}} >> chr_shift;
    prg_raw   = {regs_i.r3[HIGH_BIT], regs_i.r1};
    chr_raw   = {regs_i.r3[HIGH_BIT], regs_i.r2[REG_W-1:SHIFT_W], regs_i.r0};
    masks_o.prg_and  = prg_and;
    masks_o.chr_and  = chr_and;
    masks_o.prg_or   = prg_raw & ~{{(PRG_OR_W-PRG_AND_W){1'b0}}, prg_and};
    masks_o.chr_or   = chr_raw & ~{{(CHR_OR_W-CHR_AND_W){1'b0}}, chr_and};
    masks_o.core_sel = regs_i.r2[SEL_BIT];
  end
endmodule

// File: rtl/obc_bank_merge.sv
module obc_bank_merge #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned AND_W = 6,
  parameter int unsigned OUT_W = 9,
  localparam int unsigned IN_BITS  = SLOTS * AND_W,
  localparam int unsigned OUT_BITS = SLOTS * OUT_W
) (
  input  logic [IN_BITS-1:0]  inner_i,
  input  logic [AND_W-1:0]    and_i,
  input  logic [OUT_W-1:0]    or_i,
  output logic [OUT_BITS-1:0] bank_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [AND_W-1:0] kept;
    assign kept = inner_i[s*AND_W +: AND_W] & and_i;
    assign bank_o[s*OUT_W +: OUT_W] = {{(OUT_W-AND_W){1'b0}}, kept} | or_i;
  end
endmodule

// File: rtl/outer_bank_ctrl.sv
module outer_bank_ctrl
  import obc_pkg::*;
#(
  parameter int unsigned PRG_SLOTS = 4,
  parameter int unsigned CHR_SLOTS = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [15:0]                     cpu_addr_i,
  input  logic [7:0]                      cpu_data_i,
  input  logic                            cpu_we_i,
  input  logic [PRG_SLOTS*PRG_AND_W-1:0]  prg_inner_i,
  input  logic [CHR_SLOTS*CHR_AND_W-1:0]  chr_inner_i,
  output logic [PRG_AND_W-1:0]            prg_and_o,
  output logic [PRG_OR_W-1:0]             prg_or_o,
  output logic [CHR_AND_W-1:0]            chr_and_o,
  output logic [CHR_OR_W-1:0]             chr_or_o,
  output logic [PRG_SLOTS*PRG_OR_W-1:0]   prg_bank_o,
  output logic [CHR_SLOTS*CHR_OR_W-1:0]   chr_bank_o,
  output logic                            core_sel_o,
  output logic                            core_apply_o
);
  outer_regs_t  regs;
  outer_masks_t masks;
  logic         lock_w;

  obc_regfile #(
    .ADDR_W  (16),
    .WIN_BASE(16'h5000),
    .WIN_MASK(16'hF000)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (cpu_addr_i),
    .data_i (cpu_data_i),
    .we_i   (cpu_we_i),
    .regs_o (regs),
    .lock_o (lock_w),
    .apply_o(core_apply_o)
  );

  obc_mask_gen u_masks (
    .regs_i (regs),
    .masks_o(masks)
  );

  assign prg_and_o  = masks.prg_and;
  assign prg_or_o   = masks.prg_or;
  assign chr_and_o  = masks.chr_and;
  assign chr_or_o   = masks.chr_or;
  assign core_sel_o = masks.core_sel;

  obc_bank_merge #(.SLOTS(PRG_SLOTS), .AND_W(PRG_AND_W), .OUT_W(PRG_OR_W)) u_prg_merge (
    .inner_i(prg_inner_i),
    .and_i  (masks.prg_and),
    .or_i   (masks.prg_or),
    .bank_o (prg_bank_o)
  );

  obc_bank_merge #(.SLOTS(CHR_SLOTS), .AND_W(CHR_AND_W), .OUT_W(CHR_OR_W)) u_chr_merge (
    .inner_i(chr_inner_i),
    .and_i  (masks.chr_and),
    .or_i   (masks.chr_or),
    .bank_o (chr_bank_o)
  );
endmodule

// File: rtl/obc_checker.sv
module obc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cpu_addr_i,
  input logic        cpu_we_i,
  input logic        lock_i,
  input logic [5:0]  prg_and_i,
  input logic [8:0]  prg_or_i,
  input logic [7:0]  chr_and_i,
  input logic [12:0] chr_or_i,
  input logic        core_sel_i,
  input logic        core_apply_i
);
  logic win_hit;
  assign win_hit = cpu_we_i && ((cpu_addr_i & 16'hF000) == 16'h5000);

  AST_APPLY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_apply_i |=> !core_apply_i); // R10
  AST_APPLY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_apply_i |-> $past(win_hit)); // R10
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(prg_and_i) && $stable(prg_or_i) && $stable(chr_and_i)
                && $stable(chr_or_i) && $stable(core_sel_i) && !core_apply_i)); // R4
  AST_SEL_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_hit |=> $stable(core_sel_i)); // R9
  AST_CHR_MASK_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((({1'b0, chr_and_i} + 9'd1) & {1'b0, chr_and_i}) == 9'd0)); // R6
  AST_PRG_OR_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((prg_or_i[5:0] & prg_and_i) == 6'd0)); // R7
  AST_CHR_OR_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chr_or_i[7:0] & chr_and_i) == 8'd0)); // R8
endmodule

bind outer_bank_ctrl obc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_we_i    (cpu_we_i),
  .lock_i      (lock_w),
  .prg_and_i   (prg_and_o),
  .prg_or_i    (prg_or_o),
  .chr_and_i   (chr_and_o),
  .chr_or_i    (chr_or_o),
  .core_sel_i  (core_sel_o),
  .core_apply_i(core_apply_o)
);

// File: tb/outer_bank_ctrl_tb.sv
module outer_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NC = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [15:0]     cpu_addr_i = '0;
  logic [7:0]      cpu_data_i = '0;
  logic            cpu_we_i = 1'b0;
  logic [NP*6-1:0] prg_inner_i = '0;
  logic [NC*8-1:0] chr_inner_i = '0;
  logic [5:0]      prg_and_o;
  logic [8:0]      prg_or_o;
  logic [7:0]      chr_and_o;
  logic [12:0]     chr_or_o;
  logic [NP*9-1:0] prg_bank_o;
  logic [NC*13-1:0] chr_bank_o;
  logic            core_sel_o, core_apply_o;

  int total = 0;
  int bad = 0;

  outer_bank_ctrl u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // behavioural reference
  int m_reg [4];
  int m_idx;
  int m_pulse;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_reg = '{0, 0, 'h0F, 0};
      m_idx = 0;
      m_pulse = 0;
    end else begin
      m_pulse = 0;
      if (cpu_we_i && cpu_addr_i >= 16'h5000 && cpu_addr_i <= 16'h5FFF && m_reg[3] < 128) begin
        m_reg[m_idx] = cpu_data_i;
        if (m_idx == 2) m_pulse = 1;
        m_idx = (m_idx + 1) % 4;
      end
    end
  end

  function automatic int e_prg_and();
    return 63 - (m_reg[3] % 64);
  endfunction
  function automatic int e_chr_and();
    int sh = 15 - (m_reg[2] % 16);
    return 255 / (1 << sh);
  endfunction
  function automatic int e_prg_or();
    int v = m_reg[1] + (((m_reg[3] / 64) % 2) * 256);
    return v - (v & e_prg_and());
  endfunction
  function automatic int e_chr_or();
    int v = m_reg[0] + ((m_reg[2] / 16) * 256) + (((m_reg[3] / 64) % 2) * 4096);
    return v - (v & e_chr_and());
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, a quarter period after the edge
  always @(posedge clk_i) begin
    #(CLK_PERIOD/4);
    if (rst_ni) begin
      chk("R5 prg_and", int'(prg_and_o), e_prg_and());
      chk("R6 chr_and", int'(chr_and_o), e_chr_and());
      chk("R7 prg_or", int'(prg_or_o), e_prg_or());
      chk("R8 chr_or", int'(chr_or_o), e_chr_or());
      chk("R9 core_sel", int'(core_sel_o), (m_reg[2] / 128) % 2);
      chk("R10 core_apply", int'(core_apply_o), m_pulse);
      for (int s = 0; s < NP; s++)
        chk("R11 prg_bank", int'(prg_bank_o[s*9 +: 9]),
            (int'(prg_inner_i[s*6 +: 6]) & e_prg_and()) | e_prg_or());
      for (int s = 0; s < NC; s++)
        chk("R11 chr_bank", int'(chr_bank_o[s*13 +: 13]),
            (int'(chr_inner_i[s*8 +: 8]) & e_chr_and()) | e_chr_or());
    end
  end

  task automatic cyc(input logic we, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_we_i = we;
    cpu_addr_i = a;
    cpu_data_i = d;
    for (int s = 0; s < NP; s++) prg_inner_i[s*6 +: 6] = 6'($urandom);
    for (int s = 0; s < NC; s++) chr_inner_i[s*8 +: 8] = 8'($urandom);
    @(negedge clk_i);
    cpu_we_i = 1'b0;
  endtask

  task automatic check_reset_state();
    chk("R1 prg_and", int'(prg_and_o), 'h3F);
    chk("R1 chr_and", int'(chr_and_o), 'hFF);
    chk("R1 prg_or", int'(prg_or_o), 0);
    chk("R1 chr_or", int'(chr_or_o), 0);
    chk("R1 core_sel", int'(core_sel_o), 0);
    chk("R1 core_apply", int'(core_apply_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_reset_state();
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset_state();

    // R2: four loads in order, then a wrapping fifth load
    cyc(1'b1, 16'h5000, 8'hA5);
    cyc(1'b1, 16'h5123, 8'h3C);
    cyc(1'b1, 16'h5FFF, 8'h1B);
    chk("R10 pulse after third load", int'(core_apply_o), 1);
    cyc(1'b1, 16'h5800, 8'h08);
    chk("R10 no pulse on fourth load", int'(core_apply_o), 0);
    chk("R2 prg_or", int'(prg_or_o), 'h008);
    chk("R2 chr_or", int'(chr_or_o), 'h1A0);
    chk("R2 prg_and", int'(prg_and_o), 'h37);
    chk("R2 chr_and", int'(chr_and_o), 'h0F);
    cyc(1'b1, 16'h5000, 8'h77);
    chk("R2 wrap to reg0", int'(chr_or_o), 'h170);

    // R3: off-window writes ignored, pointer held at 1
    cyc(1'b1, 16'h4FFF, 8'hFF);
    cyc(1'b1, 16'h6000, 8'hFF);
    chk("R3 chr_or unchanged", int'(chr_or_o), 'h170);
    chk("R3 prg_or unchanged", int'(prg_or_o), 'h008);
    cyc(1'b1, 16'h5ABC, 8'hC0);
    chk("R3 pointer not advanced", int'(prg_or_o), 'h0C0);

    // R9 and R10 on the same write
    cyc(1'b1, 16'h5001, 8'h8F);
    chk("R9 core_sel set", int'(core_sel_o), 1);
    chk("R10 pulse with core change", int'(core_apply_o), 1);

    // R4: lock, then back-to-back attempts
    @(negedge clk_i);
    cpu_we_i = 1'b1; cpu_addr_i = 16'h5002; cpu_data_i = 8'hC1;
    @(negedge clk_i);
    cpu_data_i = 8'h00;
    repeat (4) @(negedge clk_i);
    cpu_we_i = 1'b0;
    chk("R4 prg_or frozen", int'(prg_or_o), 'h1C0);
    chk("R4 chr_or frozen", int'(chr_or_o), 'h1800);
    chk("R4 prg_and frozen", int'(prg_and_o), 'h3E);
    chk("R4 core_sel frozen", int'(core_sel_o), 1);
    chk("R4 no pulse", int'(core_apply_o), 0);

    // reset clears lock
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset_state();

    // mixed traffic, model judges every clock
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      d = 8'($urandom);
      if (m_idx == 3) d[7] = 1'b0;
      case ($urandom % 4)
        0, 1, 2: a = 16'h5000 | 16'($urandom % 4096);
        default: a = ($urandom % 2) ? 16'h4000 | 16'($urandom % 4096) : 16'h6000 | 16'($urandom % 4096);
      endcase
      cyc(1'($urandom % 2), a, d);
    end

    repeat (2) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule